// File: doc/BRIEF.md
# Packed Seven-Bit Text Streamer

This block sends a zero-terminated text string out of a word-organised memory, one character at a time. Each 14-bit memory word holds two 7-bit characters. The streamer is started with the low part of a word address and reads the words in order through a synchronous read port. It presents each character as an 8-bit byte on a valid/ready output, and pulses a done flag after the string ends.

The upper address bits always equal a fixed page number, which is set by a parameter. Only the low address byte counts up, and it wraps within the page. The string ends when the character in the lower half of a word is zero. The upper character of that word is still sent, so each stored string holds an even number of characters counting the zero. The zero itself is never sent.

Top module: `packed_text_streamer`

## Requirements
- R1: After reset, `outValid`, `done` and `memRdEn` are all low and stay low until a start is accepted.
- R2: For each word, the character in bits 13:7 is sent before the character in bits 6:0. Words are sent in ascending address order, starting at the word given with the start.
- R3: Every output byte has bit 7 at zero. Bits 6:0 carry the character.
- R4: A word whose bits 6:0 are zero ends the string. Its bits 13:7 character is sent, even when that character is zero. The zero in bits 6:0 is never sent, and no byte follows it.
- R5: After both characters of a word are accepted, the low address byte increases by one, wrapping from 0xFF to 0x00. The page bits of `memAddr` always equal the page parameter, which defaults to 7.
- R6: While `outValid` is high and `outReady` is low, `outValid` stays high and `outByte` does not change.
- R7: `memRdEn` is high for exactly one cycle per word. `outValid` for that word's first character rises two cycles after the cycle in which `memRdEn` is high.
- R8: `done` is high for exactly one cycle. That cycle directly follows the clock edge that accepts the last character, and `outValid` is low in it.
- R9: A start is accepted only when the block is idle. A start raised while characters are being sent, or in the cycle in which `done` is high, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request to begin a string |
| startAddr | input | 8 | Low address byte of the first word |
| memRdEn | output | 1 | Read strobe to the synchronous memory |
| memAddr | output | 11 | Word address: page bits over the low byte |
| memRdData | input | 14 | Word returned one cycle after `memRdEn` |
| outValid | output | 1 | A character byte is on `outByte` |
| outByte | output | 8 | Zero-extended character |
| outReady | input | 1 | The consumer takes `outByte` |
| done | output | 1 | One-cycle pulse at the end of a string |

## Verification
Two events can fall in the same cycle. One is a start request that arrives while the block is busy: either in the middle of a string or in the very cycle `done` is high. The other is the acceptance of the last character. The bench raises `startValid` with a different address partway through a string, and again in the `done` cycle. It then judges the result by checking that the rest of the byte stream still matches the original string and that `memRdEn` stays low in the cycle after the `done` pulse. Acceptance of a low character together with the address step is provoked under three `outReady` patterns, and the wrap of the address across 0xFF is judged from the bytes that come out.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_SEND_HI,
    ST_SEND_LO,
    ST_FINISH
  } streamState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic advance;
    logic capture;
    logic selLow;
  } ctrlStrobe_t;

endpackage

// File: rtl/pts_ctrl.sv
module pts_ctrl
  import pts_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        outReady,
  input  logic        loIsZero,
  output ctrlStrobe_t strb,
  output logic        memRdEn,
  output logic        outValid,
  output logic        done
);

  streamState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    memRdEn   = 1'b0;
    outValid  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          strb.loadAddr = 1'b1;
          stateNext     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memRdEn   = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        strb.capture = 1'b1;
        stateNext    = ST_SEND_HI;
      end
      ST_SEND_HI: begin
        outValid = 1'b1;
        if (outReady) stateNext = loIsZero ? ST_FINISH : ST_SEND_LO;
      end
      ST_SEND_LO: begin
        outValid    = 1'b1;
        strb.selLow = 1'b1;
        if (outReady) begin
          strb.advance = 1'b1;
          stateNext    = ST_FETCH;
        end
      end
      ST_FINISH: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && outValid));

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn ##1 outValid);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && startValid && !(outReady && strb.selLow)) |=> !memRdEn);

endmodule

// File: rtl/pts_datapath.sv
module pts_datapath
  import pts_pkg::*;
#(
  parameter int CHAR_W = 7,
  parameter int OUT_W  = 8,
  parameter int LO_W   = 8,
  parameter int PAGE_W = 3,
  parameter logic [PAGE_W-1:0] PAGE = '1,
  localparam int WORD_W = 2 * CHAR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic [LO_W-1:0]      startAddr,
  input  logic [WORD_W-1:0]    memRdData,
  output logic [PAGE_W+LO_W-1:0] memAddr,
  output logic [OUT_W-1:0]     outByte,
  output logic                 loIsZero
);

  logic [LO_W-1:0]   addrLo;
  logic [WORD_W-1:0] wordQ;
  logic [CHAR_W-1:0] hiChar, loChar, selChar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo <= '0;
      wordQ  <= '0;
    end else begin
      if (strb.loadAddr)     addrLo <= startAddr;
      else if (strb.advance) addrLo <= addrLo + 1'b1;
      if (strb.capture)      wordQ  <= memRdData;
    end
  end

  assign hiChar   = wordQ[WORD_W-1:CHAR_W];
  assign loChar   = wordQ[CHAR_W-1:0];
  assign selChar  = strb.selLow ? loChar : hiChar;
  assign loIsZero = (loChar == '0);
  assign memAddr  = {PAGE, addrLo};
  assign outByte  = {{(OUT_W-CHAR_W){1'b0}}, selChar};

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> addrLo == $past(addrLo) + 1'b1);

endmodule

// File: rtl/packed_text_streamer.sv
module packed_text_streamer
  import pts_pkg::*;
#(
  parameter int CHAR_W = 7,
  parameter int OUT_W  = 8,
  parameter int LO_W   = 8,
  parameter int PAGE_W = 3,
  parameter logic [PAGE_W-1:0] PAGE = 3'h7,
  localparam int WORD_W = 2 * CHAR_W,
  localparam int MEM_AW = PAGE_W + LO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [LO_W-1:0]   startAddr,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              outValid,
  output logic [OUT_W-1:0]  outByte,
  input  logic              outReady,
  output logic              done
);

  ctrlStrobe_t strb;
  logic        loIsZero;

  pts_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .outReady  (outReady),
    .loIsZero  (loIsZero),
    .strb      (strb),
    .memRdEn   (memRdEn),
    .outValid  (outValid),
    .done      (done)
  );

  pts_datapath #(
    .CHAR_W(CHAR_W),
    .OUT_W (OUT_W),
    .LO_W  (LO_W),
    .PAGE_W(PAGE_W),
    .PAGE  (PAGE)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startAddr(startAddr),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .outByte  (outByte),
    .loIsZero (loIsZero)
  );

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));

endmodule

// File: tb/test_packed_text_streamer.sv
module test_packed_text_streamer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [7:0]  startAddr = '0;
  logic        memRdEn;
  logic [10:0] memAddr;
  logic [13:0] memRdData = '0;
  logic        outValid;
  logic [7:0]  outByte;
  logic        outReady = 1'b0;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int reads = 0;
  int pageBad = 0;

  logic [13:0] mem [0:255];
  logic [6:0]  expChars [0:63];
  int          expN;

  // Each entry: {start address, ready mode, inject code}
  // ready mode 0 = always, 1 = alternate, 2 = three-cycle stall
  // inject 1 = start mid-string, 2 = start in done cycle
  localparam logic [11:0] VEC [0:5] = '{
    {8'h10, 2'd0, 2'd0},
    {8'h20, 2'd0, 2'd2},
    {8'hFE, 2'd1, 2'd1},
    {8'h30, 2'd2, 2'd0},
    {8'h10, 2'd2, 2'd1},
    {8'h40, 2'd1, 2'd2}
  };

  always #10 clk = ~clk;

  packed_text_streamer i_packed_text_streamer (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .outValid(outValid), .outByte(outByte), .outReady(outReady), .done(done)
  );

  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr[7:0]];

  always @(negedge clk) if (rstN && memRdEn) begin
    reads++;
    if (memAddr[10:8] != 3'h7) pageBad++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic void buildExpected(input logic [7:0] a0);
    logic [7:0] a = a0;
    expN = 0;
    for (int k = 0; k < 64; k++) begin
      expChars[expN] = mem[a][13:7];
      expN++;
      if (mem[a][6:0] == 7'd0) break;
      expChars[expN] = mem[a][6:0];
      expN++;
      a = a + 8'd1;
    end
  endfunction

  task automatic runString(input logic [7:0] addr, input logic [1:0] mode,
                           input logic [1:0] inject);
    int  got = 0;
    int  guard = 0;
    int  stall = 0;
    bit  tick = 0;
    bit  pending = 0;
    bit  injDone = 0;
    bit  rdy;
    logic [7:0] prevByte = '0;
    buildExpected(addr);
    @(negedge clk);
    startValid = 1'b1;
    startAddr  = addr;
    @(negedge clk);
    startValid = 1'b0;
    while (got < expN && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (inject == 2'd1 && got == 1 && !injDone) begin
        startValid = 1'b1;
        startAddr  = 8'h20;
        injDone    = 1;
      end else begin
        startValid = 1'b0;
      end
      if (outValid) begin
        if (pending) check(outByte == prevByte, "R6 held byte", outByte, prevByte);
        case (mode)
          2'd0: rdy = 1;
          2'd1: begin tick = ~tick; rdy = tick; end
          default: begin
            if (stall < 3) begin stall++; rdy = 0; end
            else begin stall = 0; rdy = 1; end
          end
        endcase
        if (rdy) begin
          // R9 covered: stream unchanged after mid-string start
          check(outByte[6:0] == expChars[got], "R2 char order", outByte, expChars[got]);
          check(outByte[7] == 1'b0, "R3 bit7 clear", outByte, {1'b0, outByte[6:0]});
          got++;
          pending = 0;
        end else begin
          pending  = 1;
          prevByte = outByte;
        end
        outReady = rdy;
      end else begin
        outReady = 1'b0;
      end
    end
    @(negedge clk);
    outReady   = 1'b0;
    startValid = 1'b0;
    check(got == expN, "R4 byte count", got, expN);
    check(done == 1'b1, "R8 done after last byte", done, 1);
    check(outValid == 1'b0, "R4 nothing after terminator", outValid, 0);
    if (inject == 2'd2) begin
      startValid = 1'b1;
      startAddr  = 8'h20;
    end
    @(negedge clk);
    startValid = 1'b0;
    check(done == 1'b0, "R8 done one cycle", done, 0);
    if (inject == 2'd2) check(memRdEn == 1'b0, "R9 start in done cycle ignored", memRdEn, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {7'h2E, 7'h00};
    mem[8'h10] = {7'h48, 7'h69};
    mem[8'h11] = {7'h61, 7'h62};
    mem[8'h12] = {7'h63, 7'h00};
    mem[8'h20] = {7'h5A, 7'h00};
    mem[8'hFE] = {7'h57, 7'h72};
    mem[8'hFF] = {7'h61, 7'h70};
    mem[8'h00] = {7'h21, 7'h00};
    mem[8'h30] = {7'h00, 7'h78};
    mem[8'h31] = {7'h79, 7'h00};
    for (int i = 0; i < 5; i++) mem[8'h40 + i] = {7'(7'h41 + i), 7'(7'h61 + i)};
    mem[8'h45] = {7'h7F, 7'h00};

    repeat (3) @(negedge clk);
    check(outValid == 0 && done == 0 && memRdEn == 0, "R1 reset outputs",
          {outValid, done, memRdEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(outValid == 0 && done == 0 && memRdEn == 0, "R1 idle after reset",
          {outValid, done, memRdEn}, 0);

    // R7: read latency from start
    startValid = 1'b1;
    startAddr  = 8'h20;
    @(negedge clk);
    startValid = 1'b0;
    check(memRdEn == 1 && outValid == 0, "R7 read issued", {memRdEn, outValid}, 2'b10);
    @(negedge clk);
    check(memRdEn == 0 && outValid == 0, "R7 data wait", {memRdEn, outValid}, 0);
    @(negedge clk);
    check(outValid == 1 && outByte == 8'h5A, "R7 first byte", outByte, 8'h5A);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(done == 1, "R8 single-word done", done, 1);
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) runString(VEC[v][11:4], VEC[v][3:2], VEC[v][1:0]);

    check(pageBad == 0 && reads > 0, "R5 page bits fixed", pageBad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule